// File: doc/BRIEF.md
# Serial Controller Clock Divider Chain

This block turns one peripheral clock into the single-cycle enable pulses that a serial protocol engine runs on. Nothing in it gates a real clock. Every output is a strobe in the peripheral clock domain that is high for exactly one cycle. The reference tick is every enabled cycle. From it a protocol tick is formed, either at full rate or at half rate. A 10-bit divider turns the protocol tick into a divided tick.

A four-way selector picks the sample tick from four sources: the divided tick, the protocol tick, an external serial-clock tick or the reference tick. The sample tick then passes through a small pre-divider and then a denominator divider, and the last of these gives the oversampling strobe. A 10-bit time measurement counter counts either protocol ticks or divided ticks.

All divide values are live inputs. Each divider counts down from its reload value. A new value is picked up only at the next terminal count, so a period is never cut short. Pulling the enable low restarts the whole chain from its reload values.

Top module: `tick_chain`

## Requirements
- R1: With `half_sel` = 0 and the chain enabled, `prot_tick_o` is high in every cycle.
- R2: With `half_sel` = 1, `prot_tick_o` is high in every second enabled cycle. The first pulse comes in the second cycle after enable.
- R3: `div_tick_o` pulses once for every `clk_div`+1 protocol ticks, on the (`clk_div`+1)-th tick after enable. With `clk_div` = 0, every protocol tick passes through.
- R4: `samp_src` selects the sample tick: 0 selects the divided tick, 1 the protocol tick, 2 `ext_tick`, and 3 every enabled cycle. With any other code than 2, `ext_tick` has no effect on any output.
- R5: `pre_tick_o` pulses once for every `pre_div`+1 sample ticks.
- R6: `strobe_o` pulses once for every `den_div`+1 pre-divider ticks.
- R7: A divide value changed in mid-period has no effect on the running period. It applies from the period that begins after the next terminal count.
- R8: `tm_count_o` rises by one in the cycle after each selected tick while `tm_en` = 1, and wraps from 1023 to 0. `tm_src` = 0 selects protocol ticks and `tm_src` = 1 selects divided ticks. While `tm_en` = 0 the count holds.
- R9: While `en` = 0, and in the first cycle after reset, every tick output is 0. All dividers reload, and `tm_count_o` clears to 0 at the next edge. After reset all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable for the chain |
| half_sel | input | 1 | 1 = protocol tick at half the reference rate |
| clk_div | input | 10 | Divided-tick divide value minus one |
| samp_src | input | 2 | Sample tick source code |
| pre_div | input | 2 | Pre-divider divide value minus one |
| den_div | input | 5 | Denominator divide value minus one |
| tm_en | input | 1 | Time measurement counter enable |
| tm_src | input | 1 | Measurement source: 0 protocol tick, 1 divided tick |
| ext_tick | input | 1 | Synchronized serial-clock tick pulse |
| prot_tick_o | output | 1 | Protocol tick |
| div_tick_o | output | 1 | Divided tick |
| samp_tick_o | output | 1 | Selected sample tick |
| pre_tick_o | output | 1 | Pre-divider tick |
| strobe_o | output | 1 | Oversampling strobe |
| tm_count_o | output | 10 | Time measurement count |

## Verification
A wrong count or reload value in any divider shifts the position of that divider's next pulse. Because the stages are chained, every downstream pulse moves with it. The error therefore shows up at the ports within one period of the faulty stage. A stale half-rate toggle shows up at once, as two adjacent protocol ticks or a missing one. A stuck measurement counter is visible one cycle after the first selected tick. The bench compares all six outputs in every cycle against a model that counts upward. This catches each of these failures at the first cycle it appears.

// File: rtl/tick_chain_pkg.sv
package tick_chain_pkg;
   typedef enum logic [1:0] {
      SRC_DIV  = 2'd0,
      SRC_PROT = 2'd1,
      SRC_EXT  = 2'd2,
      SRC_REF  = 2'd3
   } samp_src_e;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick_i,
   input  logic [W-1:0] reload_i,
   output logic         tick_o
);
   if (W < 1) begin : g_bad_width
      $error("tick_div: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic         at_term;

   assign at_term = (cnt_q == '0);
   assign tick_o  = run & tick_i & at_term;

   // Count down; reload only when stopped or at terminal count (R7).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= reload_i;
      end else if (tick_i) begin
         if (at_term) cnt_q <= reload_i;
         else         cnt_q <= cnt_q - 1'b1;
      end
   end

   a_r3_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick_i) |=> $stable(cnt_q));

   a_r3_step_down : assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tick_src_sel.sv
module tick_src_sel
   import tick_chain_pkg::*;
(
   input  logic       div_i,
   input  logic       prot_i,
   input  logic       ext_i,
   input  logic       ref_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   samp_src_e src;
   assign src = samp_src_e'(sel_i);

   always_comb begin
      case (src)
         SRC_DIV:  tick_o = div_i;
         SRC_PROT: tick_o = prot_i;
         SRC_EXT:  tick_o = ext_i;
         default:  tick_o = ref_i;
      endcase
   end
endmodule

// File: rtl/tick_meter.sv
module tick_meter #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         en_i,
   input  logic         src_i,
   input  logic         prot_i,
   input  logic         div_i,
   output logic [W-1:0] count_o
);
   if (W < 1) begin : g_bad_width
      $error("tick_meter: W must be at least 1");
   end

   logic pick;
   assign pick = src_i ? div_i : prot_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count_o <= '0;
      else if (!run)           count_o <= '0;
      else if (en_i && pick)   count_o <= count_o + 1'b1;
   end

   a_r8_hold_when_off : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !en_i) |=> $stable(count_o));

   a_r9_clear_when_stopped : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count_o == '0));
endmodule

// File: rtl/tick_chain.sv
module tick_chain #(
   parameter int CLK_DIV_W    = 10,
   parameter int PRE_W        = 2,
   parameter int DEN_W        = 5,
   parameter int TM_W         = 10,
   parameter bit HALF_RATE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 half_sel,
   input  logic [CLK_DIV_W-1:0] clk_div,
   input  logic [1:0]           samp_src,
   input  logic [PRE_W-1:0]     pre_div,
   input  logic [DEN_W-1:0]     den_div,
   input  logic                 tm_en,
   input  logic                 tm_src,
   input  logic                 ext_tick,
   output logic                 prot_tick_o,
   output logic                 div_tick_o,
   output logic                 samp_tick_o,
   output logic                 pre_tick_o,
   output logic                 strobe_o,
   output logic [TM_W-1:0]      tm_count_o
);
   if (CLK_DIV_W < 1 || PRE_W < 1 || DEN_W < 1 || TM_W < 1) begin : g_bad_cfg
      $error("tick_chain: all widths must be at least 1");
   end

   // First cycle after reset behaves as disabled so dividers pick up reloads (R9).
   logic arm_q;
   logic run;
   logic ref_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= 1'b1;
   end

   assign run      = en & arm_q;
   assign ref_tick = run;

   if (HALF_RATE_EN) begin : g_half
      logic tgl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   tgl_q <= 1'b0;
         else if (run) tgl_q <= ~tgl_q;
         else          tgl_q <= 1'b0;
      end
      assign prot_tick_o = run & (~half_sel | tgl_q);
   end else begin : g_full
      assign prot_tick_o = run;
   end

   tick_div #(.W(CLK_DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick_i   (prot_tick_o),
      .reload_i (clk_div),
      .tick_o   (div_tick_o)
   );

   tick_src_sel u_sel (
      .div_i  (div_tick_o),
      .prot_i (prot_tick_o),
      .ext_i  (ext_tick & run),
      .ref_i  (ref_tick),
      .sel_i  (samp_src),
      .tick_o (samp_tick_o)
   );

   tick_div #(.W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick_i   (samp_tick_o),
      .reload_i (pre_div),
      .tick_o   (pre_tick_o)
   );

   tick_div #(.W(DEN_W)) u_den (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick_i   (pre_tick_o),
      .reload_i (den_div),
      .tick_o   (strobe_o)
   );

   tick_meter #(.W(TM_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .en_i    (tm_en),
      .src_i   (tm_src),
      .prot_i  (prot_tick_o),
      .div_i   (div_tick_o),
      .count_o (tm_count_o)
   );

   a_r1_full_rate : assert property (@(posedge clk) disable iff (!rst_n)
      (en && arm_q && !half_sel) |-> prot_tick_o);

   a_r2_no_adjacent : assert property (@(posedge clk) disable iff (!rst_n)
      (en && half_sel && prot_tick_o) |=> !(half_sel && prot_tick_o));
endmodule

// File: tb/tick_chain_bench.sv
module tick_chain_bench;
   typedef struct packed {
      logic       p;
      logic       d;
      logic       s;
      logic       r;
      logic       st;
      logic [9:0] tm;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, half_sel = 1'b0, tm_en = 1'b0, tm_src = 1'b0, ext_tick = 1'b0;
   logic [9:0] clk_div = '0;
   logic [1:0] samp_src = '0;
   logic [1:0] pre_div = '0;
   logic [4:0] den_div = '0;
   logic       prot_tick_o, div_tick_o, samp_tick_o, pre_tick_o, strobe_o;
   logic [9:0] tm_count_o;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R9";
   exp_t q[$];

   // Model state: upward counters per stage
   int c_up[3];
   int per[3];
   int m_tgl;
   int m_tm;

   always #10 clk = ~clk;

   tick_chain u_tick_chain (
      .clk(clk), .rst_n(rst_n), .en(en), .half_sel(half_sel), .clk_div(clk_div),
      .samp_src(samp_src), .pre_div(pre_div), .den_div(den_div), .tm_en(tm_en),
      .tm_src(tm_src), .ext_tick(ext_tick), .prot_tick_o(prot_tick_o),
      .div_tick_o(div_tick_o), .samp_tick_o(samp_tick_o), .pre_tick_o(pre_tick_o),
      .strobe_o(strobe_o), .tm_count_o(tm_count_o)
   );

   // Monitor: pops one expected item per cycle, mid-low-phase
   always @(negedge clk) begin
      #5;
      if (q.size() > 0) begin
         exp_t e;
         exp_t a;
         e = q.pop_front();
         a = '{p: prot_tick_o, d: div_tick_o, s: samp_tick_o, r: pre_tick_o,
               st: strobe_o, tm: tm_count_o};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s t=%0t actual %h expected %h", cur_tag, $time, a, e);
         end
      end
   end

   function automatic bit st_out(int i, bit tk);
      return tk && (c_up[i] == per[i]);
   endfunction

   task automatic st_upd(int i, bit tk, int cfg);
      if (tk) begin
         if (c_up[i] == per[i]) begin
            c_up[i] = 0;
            per[i]  = cfg;
         end else begin
            c_up[i]++;
         end
      end
   endtask

   // Driver: applies inputs for one cycle and pushes the expected outputs
   task automatic drive_cycle(input bit en_v, input bit h, input int dv, input int src,
                              input int pv, input int dn, input bit te, input bit ts,
                              input bit ext_v);
      exp_t e;
      bit run, pr, dt, sm, pt, sb;
      @(negedge clk);
      en = en_v; half_sel = h; clk_div = 10'(dv); samp_src = 2'(src);
      pre_div = 2'(pv); den_div = 5'(dn); tm_en = te; tm_src = ts; ext_tick = ext_v;
      run = en_v;
      pr  = run && (!h || m_tgl == 1);
      dt  = run && st_out(0, pr);
      case (src)
         0: sm = dt;
         1: sm = pr;
         2: sm = run && ext_v;
         default: sm = run;
      endcase
      pt = run && st_out(1, sm);
      sb = run && st_out(2, pt);
      e = '{p: pr, d: dt, s: sm, r: pt, st: sb, tm: 10'(m_tm)};
      q.push_back(e);
      if (!run) begin
         m_tgl = 0; m_tm = 0;
         foreach (c_up[i]) c_up[i] = 0;
         per[0] = dv; per[1] = pv; per[2] = dn;
      end else begin
         m_tgl = 1 - m_tgl;
         st_upd(0, pr, dv);
         st_upd(1, sm, pv);
         st_upd(2, pt, dn);
         if (te && (ts ? dt : pr)) m_tm = (m_tm + 1) % 1024;
      end
   endtask

   task automatic run_case(string tag, bit h, int dv, int src, int pv, int dn,
                           bit te, bit ts, int ext_per, int n,
                           int chg_at, int chg_dv, int tmoff_at);
      int d_now;
      bit te_now;
      cur_tag = tag;
      d_now = dv;
      te_now = te;
      for (int k = 0; k < n; k++) begin
         bit xv;
         if (k == chg_at) d_now = chg_dv;
         if (k == tmoff_at) te_now = 1'b0;
         xv = (ext_per > 0) && ((k % ext_per) == ext_per - 1);
         drive_cycle(1'b1, h, d_now, src, pv, dn, te_now, ts, xv);
      end
      for (int k = 0; k < 3; k++)
         drive_cycle(1'b0, h, d_now, src, pv, dn, te_now, ts, 1'b1);
   endtask

   initial begin
      m_tgl = 0; m_tm = 0;
      foreach (c_up[i]) begin c_up[i] = 0; per[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      checks++;
      if ({prot_tick_o, div_tick_o, samp_tick_o, pre_tick_o, strobe_o, tm_count_o} !== 15'd0) begin
         errors++;
         $display("FAIL R9 reset state actual %h expected 0",
                  {prot_tick_o, div_tick_o, samp_tick_o, pre_tick_o, strobe_o, tm_count_o});
      end
      // R9: disabled cycles with ext pulses present
      for (int k = 0; k < 2; k++) drive_cycle(1'b0, 1'b0, 0, 2, 0, 0, 1'b1, 1'b0, 1'b1);
      // R1 R4: everything at full rate, protocol source
      run_case("R1/R4", 1'b0, 0, 1, 0, 0, 1'b1, 1'b0, 0, 20, -1, 0, -1);
      // R2 R3 R5 R6 R8: half rate, divided source
      run_case("R2/R3/R5/R6/R8", 1'b1, 2, 0, 1, 3, 1'b1, 1'b0, 0, 200, -1, 0, -1);
      // R4 R8: external source, measurement of divided ticks
      run_case("R4/R8", 1'b0, 3, 2, 2, 1, 1'b1, 1'b1, 3, 150, -1, 0, -1);
      // R4 R6: reference source, largest denominator
      run_case("R4/R6", 1'b1, 5, 3, 3, 31, 1'b0, 1'b0, 0, 300, -1, 0, -1);
      // R4: ext_tick ignored when source is divided tick
      run_case("R4", 1'b0, 1, 0, 1, 2, 1'b0, 1'b0, 1, 80, -1, 0, -1);
      // R7: divide value change mid-period
      run_case("R7", 1'b0, 4, 0, 0, 0, 1'b1, 1'b1, 0, 40, 7, 1, -1);
      run_case("R7", 1'b0, 1, 0, 0, 0, 1'b1, 1'b1, 0, 40, 5, 6, -1);
      // R8: counter holds once disabled
      run_case("R8", 1'b0, 2, 1, 0, 0, 1'b1, 1'b0, 0, 60, -1, 0, 25);
      // R8: wrap past 1023
      run_case("R8 wrap", 1'b0, 0, 1, 0, 0, 1'b1, 1'b0, 0, 1100, -1, 0, -1);
      // R3: pass-through with half rate
      run_case("R3/R9", 1'b1, 0, 0, 0, 0, 1'b1, 1'b1, 0, 30, -1, 0, -1);
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule